// File: doc/BRIEF.md
# Multiplexed BCD digit scanner

This block drives a three-digit numeric display through one shared 4-bit BCD bus and three active-low digit strobes. A producer hands it a reading as three BCD digits plus a sign flag and two overrange flags, marked by a one-cycle `rd_valid` pulse. The scanner shows the digits one at a time. It lowers the strobe of the digit whose code is on the bus, so a latch or decoder placed after each strobe can capture its own digit.

The scan visits the least significant digit first, then the most significant, then the middle one, and repeats. Each strobe stays low for `DWELL` clocks. A single blanking clock with all strobes high separates consecutive digits, and the bus changes only in that blank clock. A new reading is taken into the display frame only when a frame starts, so a frame never mixes digits from two readings. Some readings replace the digit codes with reserved codes. A negative reading carries a minus code (1010) in the most significant position. Negative overrange fills every position with 1010. Positive overrange fills every position with 1011.

Top module: `digit_scanner`

## Requirements
- R1: After reset, and until the first `rd_valid` pulse, all three strobes stay high and `bcd` is 0000.
- R2: Strobes fire in the repeating order least significant (`sel_lsd_n`), most significant (`sel_msd_n`), next significant (`sel_nsd_n`).
- R3: Each strobe, once low, stays low for exactly `DWELL` consecutive clocks, and no two strobes are ever low together.
- R4: Exactly one clock with all strobes high separates two digits. `bcd` does not change while a strobe stays low.
- R5: With no flag set, the positions show `rd_hund` (most significant), `rd_tens` (next) and `rd_ones` (least), unchanged.
- R6: With `rd_neg` set and no overrange flag, the most significant position shows 1010 and the other two show `rd_tens` and `rd_ones`.
- R7: With `rd_ovr_neg` set, every position shows 1010. This takes priority over all other flags.
- R8: With `rd_ovr_pos` set and `rd_ovr_neg` clear, every position shows 1011, whatever `rd_neg` is.
- R9: A reading that arrives during a frame is shown from the next frame on. This includes a reading that arrives in the frame's last clock. The current frame keeps its reading. Of several readings within one frame, the last one wins.
- R10: The first reading starts a frame on the next clock. That clock is blank with the least significant code already on `bcd`, and `sel_lsd_n` falls on the clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | One-cycle pulse marking a new reading |
| rd_hund | input | 4 | Hundreds digit, BCD |
| rd_tens | input | 4 | Tens digit, BCD |
| rd_ones | input | 4 | Units digit, BCD |
| rd_neg | input | 1 | Reading is negative |
| rd_ovr_pos | input | 1 | Positive overrange |
| rd_ovr_neg | input | 1 | Negative overrange |
| bcd | output | 4 | Shared BCD digit bus |
| sel_msd_n | output | 1 | Most significant digit strobe, active low |
| sel_nsd_n | output | 1 | Next significant digit strobe, active low |
| sel_lsd_n | output | 1 | Least significant digit strobe, active low |

## Verification
A new reading can arrive in the same clock as the frame wrap, when the last middle-digit clock hands over to the next least significant blank. The bench provokes this by pulsing `rd_valid` exactly on the final clock of the `sel_nsd_n` window. It judges the result by requiring that the following frame shows the new reading in all three positions. It also pulses readings in the middle of a frame and requires that the rest of that frame keeps the old codes, with `bcd` held steady while the strobe is low.

// File: rtl/digit_scanner.sv
module digit_scanner #(
  parameter int DWELL = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_valid,
  input  logic [3:0] rd_hund,
  input  logic [3:0] rd_tens,
  input  logic [3:0] rd_ones,
  input  logic       rd_neg,
  input  logic       rd_ovr_pos,
  input  logic       rd_ovr_neg,
  output logic [3:0] bcd,
  output logic       sel_msd_n,
  output logic       sel_nsd_n,
  output logic       sel_lsd_n
);
  localparam int SLOT = DWELL + 1;
  localparam int CW   = $clog2(SLOT);
  localparam int FW   = 15;
  localparam logic [1:0] S_LSD = 2'd0, S_MSD = 2'd1, S_NSD = 2'd2;
  localparam logic [3:0] C_MINUS = 4'hA, C_OVER = 4'hB;

  logic          active;
  logic [1:0]    slot;
  logic [CW-1:0] cnt;
  logic [FW-1:0] frame, pend;
  logic [3:0]    dig;

  wire [FW-1:0] rd_word  = {rd_ovr_neg, rd_ovr_pos, rd_neg, rd_hund, rd_tens, rd_ones};
  wire [FW-1:0] pend_nx  = rd_valid ? rd_word : pend;
  wire          slot_end = (cnt == CW'(SLOT - 1));
  wire          driving  = active && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      slot   <= S_LSD;
      cnt    <= '0;
      frame  <= '0;
      pend   <= '0;
    end else if (!active) begin
      if (rd_valid) begin
        active <= 1'b1;
        frame  <= rd_word;
        pend   <= rd_word;
        slot   <= S_LSD;
        cnt    <= '0;
      end
    end else begin
      pend <= pend_nx;
      if (slot_end) begin
        cnt <= '0;
        if (slot == S_NSD) begin
          slot  <= S_LSD;
          frame <= pend_nx;
        end else begin
          slot <= 2'(slot + 2'd1);
        end
      end else begin
        cnt <= CW'(cnt + 1'b1);
      end
    end
  end

  always_comb begin
    case (slot)
      S_LSD:   dig = frame[3:0];
      S_MSD:   dig = frame[11:8];
      default: dig = frame[7:4];
    endcase
    if (!active)                         bcd = 4'h0;
    else if (frame[14])                  bcd = C_MINUS;
    else if (frame[13])                  bcd = C_OVER;
    else if (frame[12] && slot == S_MSD) bcd = C_MINUS;
    else                                 bcd = dig;
  end

  assign sel_lsd_n = !(driving && slot == S_LSD);
  assign sel_msd_n = !(driving && slot == S_MSD);
  assign sel_nsd_n = !(driving && slot == S_NSD);
endmodule

// File: rtl/digit_scanner_chk.sv
module digit_scanner_chk #(
  parameter int DWELL = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_valid,
  input logic [3:0] bcd,
  input logic       sel_msd_n,
  input logic       sel_nsd_n,
  input logic       sel_lsd_n
);
  localparam int RW = $clog2(DWELL + 2) + 1;

  wire [2:0] lowv   = ~{sel_msd_n, sel_nsd_n, sel_lsd_n};
  wire       any_lo = |lowv;

  logic          seen, was_lo, have_last;
  logic [2:0]    last;
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; was_lo <= 1'b0; have_last <= 1'b0; last <= '0; run <= '0;
    end else begin
      if (rd_valid) seen <= 1'b1;
      was_lo <= any_lo;
      if (any_lo) begin
        last <= lowv; have_last <= 1'b1;
        run  <= RW'(run + 1'b1);
      end else begin
        run <= '0;
      end
    end
  end

  function automatic logic [2:0] succ(input logic [2:0] v);
    case (v)
      3'b001:  succ = 3'b100;
      3'b100:  succ = 3'b010;
      default: succ = 3'b001;
    endcase
  endfunction

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (lowv == 3'b000 && bcd == 4'h0));

  assert_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (any_lo && !was_lo && have_last) |-> (lowv == succ(last)));

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lowv) <= 1);

  assert_dwell_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (was_lo && !any_lo) |-> (run == RW'(DWELL)));

  assert_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_lo && was_lo) |-> (lowv == last));

  assert_bus_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_lo && was_lo) |-> $stable(bcd));
endmodule

bind digit_scanner digit_scanner_chk #(.DWELL(DWELL)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .bcd(bcd),
  .sel_msd_n(sel_msd_n), .sel_nsd_n(sel_nsd_n), .sel_lsd_n(sel_lsd_n)
);

// File: tb/test_digit_scanner.sv
module test_digit_scanner;
  localparam int DWELL = 6;

  logic clk = 1'b0, rst_n = 1'b0, rd_valid = 1'b0;
  logic [14:0] word = '0;
  logic [3:0] bcd;
  logic sel_msd_n, sel_nsd_n, sel_lsd_n;
  int errors = 0, checks = 0, cycles = 0;

  always #2 clk = ~clk;

  digit_scanner #(.DWELL(DWELL)) i_digit_scanner (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid),
    .rd_hund(word[11:8]), .rd_tens(word[7:4]), .rd_ones(word[3:0]),
    .rd_neg(word[12]), .rd_ovr_pos(word[13]), .rd_ovr_neg(word[14]),
    .bcd(bcd), .sel_msd_n(sel_msd_n), .sel_nsd_n(sel_nsd_n), .sel_lsd_n(sel_lsd_n));

  wire [2:0] lv = ~{sel_msd_n, sel_nsd_n, sel_lsd_n};

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic [14:0] mk(input int h, t, o, input bit ng, op, on);
    return {on, op, ng, 4'(h), 4'(t), 4'(o)};
  endfunction

  // slot 0 = least, 1 = most, 2 = next significant
  function automatic [3:0] exp_code(input int s, input [14:0] w);
    if (w[14]) return 4'hA;
    if (w[13]) return 4'hB;
    if (w[12] && s == 1) return 4'hA;
    case (s)
      0: return w[3:0];
      1: return w[11:8];
      default: return w[7:4];
    endcase
  endfunction

  function automatic [2:0] exp_lv(input int s);
    case (s)
      0: return 3'b001;
      1: return 3'b100;
      default: return 3'b010;
    endcase
  endfunction

  function automatic string tag_of(input [14:0] w);
    if (w[14]) return "R7";
    if (w[13]) return "R8";
    if (w[12]) return "R6";
    return "R5";
  endfunction

  task automatic send(input [14:0] w);
    @(negedge clk); word = w; rd_valid = 1'b1;
    @(negedge clk); rd_valid = 1'b0;
  endtask

  task automatic sync_frame();
    while (lv != 3'b001) @(negedge clk);
    while (lv == 3'b001) @(negedge clk);
    while (lv != 3'b001) @(negedge clk);
  endtask

  // entered on the first sample with sel_lsd_n low; mode bit0 injects i1
  // at the start of the most significant window, bit1 injects i2 in the frame's last clock
  task automatic check_frame(input [14:0] w, input int mode, input [14:0] i1, input [14:0] i2,
                             input string tag);
    string t = (tag != "") ? tag : tag_of(w);
    for (int s = 0; s < 3; s++) begin
      int blank = 0, run = 0;
      bit moved = 0;
      logic [3:0] first;
      while (lv == 3'b000) begin blank++; @(negedge clk); end
      if (s > 0) chk(blank == 1, "R4 blank", blank, 1);
      chk(lv == exp_lv(s), "R2 order", lv, exp_lv(s));
      chk(bcd == exp_code(s, w), t, bcd, exp_code(s, w));
      first = bcd;
      while (lv == exp_lv(s)) begin
        if (bcd != first) moved = 1;
        if (mode[0] && s == 1 && run == 0) begin word = i1; rd_valid = 1'b1; end
        else if (mode[1] && s == 2 && run == DWELL - 1) begin word = i2; rd_valid = 1'b1; end
        else rd_valid = 1'b0;
        run++;
        @(negedge clk);
      end
      rd_valid = 1'b0;
      chk(run == DWELL, "R3 dwell", run, DWELL);
      chk(!moved, "R4 bus steady", moved, 0);
    end
  endtask

  task automatic to_lsd();
    while (lv != 3'b001) @(negedge clk);
  endtask

  initial begin
    logic [14:0] a, b, c, d, e;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(lv == 3'b000 && bcd == 4'h0, "R1 idle", {lv, bcd}, 0);
    end

    a = mk(1, 2, 3, 0, 0, 0);
    @(negedge clk); word = a; rd_valid = 1'b1;
    @(negedge clk); rd_valid = 1'b0;
    chk(lv == 3'b000, "R10 first blank", lv, 0);
    chk(bcd == 4'h3, "R10 first code", bcd, 3);
    @(negedge clk);
    chk(lv == 3'b001, "R10 lsd strobe", lv, 1);
    check_frame(a, 0, '0, '0, "");

    foreach (a[k]) begin end
    send(mk(0, 4, 7, 1, 0, 0)); sync_frame(); check_frame(mk(0, 4, 7, 1, 0, 0), 0, '0, '0, "");
    send(mk(9, 9, 9, 1, 0, 1)); sync_frame(); check_frame(mk(9, 9, 9, 1, 0, 1), 0, '0, '0, "");
    send(mk(5, 6, 7, 0, 1, 0)); sync_frame(); check_frame(mk(5, 6, 7, 0, 1, 0), 0, '0, '0, "");
    send(mk(0, 0, 0, 0, 1, 1)); sync_frame(); check_frame(mk(0, 0, 0, 0, 1, 1), 0, '0, '0, "R7");
    send(mk(0, 1, 2, 1, 1, 0)); sync_frame(); check_frame(mk(0, 1, 2, 1, 1, 0), 0, '0, '0, "R8");
    send(mk(9, 0, 9, 0, 0, 0)); sync_frame(); check_frame(mk(9, 0, 9, 0, 0, 0), 0, '0, '0, "");

    a = mk(3, 1, 4, 0, 0, 0); b = mk(2, 7, 1, 0, 0, 0); c = mk(0, 5, 8, 1, 0, 0);
    d = mk(6, 6, 6, 0, 0, 0); e = mk(8, 0, 2, 0, 0, 0);
    send(a); sync_frame();
    check_frame(a, 1, b, '0, "R9 mid-frame keep");
    to_lsd(); check_frame(b, 2, '0, c, "R9 next frame");
    to_lsd(); check_frame(c, 3, d, e, "R9 wrap arrival");
    to_lsd(); check_frame(e, 0, '0, '0, "R9 last wins");

    for (int n = 0; n < 25; n++) begin
      logic [14:0] w;
      int r = $urandom_range(0, 9);
      w = mk($urandom_range(0, 9), $urandom_range(0, 9), $urandom_range(0, 9),
             r < 3, r == 8, r == 9);
      if (w[12]) w[11:8] = 4'h0;
      send(w); sync_frame(); check_frame(w, 0, '0, '0, "");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule